// File: doc/BRIEF.md
# Add-Only Memory Command Controller

This block is the memory-command layer of a single-wire slave that holds one-time-programmable storage. A separate bus interface does the slot timing and the ROM-level selection. It hands this block whole received bytes, one strobe per read slot, a bus-reset strobe and a strobe that marks a detected programming pulse. In return, the block supplies the bit to drive in each read slot. Storage is a 128-byte data array in four 32-byte pages, plus an 8-byte status array. Programming can only clear bits.

Every command starts with a command byte and a two-byte start address, low byte first. Read commands return a CRC-8 over the command and the address, then stream data. Write commands also take a data byte into a one-byte scratchpad and return a CRC. They then wait for a programming pulse and replay the programmed byte for verification. After that they step to the next address and accept another data byte.

The controller is one state machine. Its states are:

| State | Role |
|---|---|
| S_IDLE | Waits for a command byte. |
| S_ADDR_LO, S_ADDR_HI | Collect the start address. |
| S_DATA | Takes a byte into the scratchpad (write commands). |
| S_SEND_CRC | Sends the command CRC. |
| S_WAIT_PROG | Waits for a programming pulse. |
| S_PROG | Programs the byte. |
| S_VERIFY | Sends the stored byte back. |
| S_RD_DATA, S_RD_CRC | Stream data and trailing CRCs. |
| S_ONES | Returns all ones. |
| S_BAD | Reached on an unknown command. |

The transitions are:
- **Command byte:** S_IDLE goes to S_ADDR_LO on a known command, or to S_BAD on an unknown one.
- **Address and data bytes:** S_ADDR_LO goes to S_ADDR_HI. S_ADDR_HI goes to S_DATA for writes, or to S_SEND_CRC for reads. S_DATA goes to S_SEND_CRC.
- **End of the command CRC:** S_SEND_CRC goes to S_WAIT_PROG for writes, or to S_RD_DATA for reads.
- **Write cycle:** S_WAIT_PROG goes to S_PROG on a pulse. S_PROG goes to S_VERIFY. At the end of the verify byte, S_VERIFY goes to S_DATA.
- **Read streaming:** S_RD_DATA goes to S_RD_CRC at the end of a field or page. S_RD_CRC goes back to S_RD_DATA for the next page, or to S_ONES.
- **Bus reset:** any state goes to S_IDLE.

Top module: `amem_eprom_ctl`

## Requirements
- R1: A command is a command byte followed by address low and address high bytes. The next 8 read slots return a CRC-8 over the command byte and the masked address bytes, with the data byte included for write commands. The CRC uses polynomial x^8+x^5+x^4+1, starts at 00h and takes bits LSB first.
- R2: Command F0h streams data bytes from the start address up to byte 127. It then sends the CRC of all data bytes sent, starting from 00h.
- R3: Command C3h streams data bytes to the end of the current 32-byte page, then sends a CRC of the bytes sent in that page. It then continues at the next page with the CRC restarted from 00h, and sends ones after the CRC of page 3.
- R4: Command AAh streams status bytes from the start address through byte 7, then sends their CRC. Status byte 7 always reads 00h, and a write to it has no effect.
- R5: Command 0Fh (data) or 55h (status) loads the data byte into the scratchpad. A programming pulse in S_WAIT_PROG sets the addressed byte to the old value ANDed with the scratchpad. The next 8 read slots return the stored byte.
- R6: At the end of the verify byte, the address increments and wraps at the end of its field (127 to 0 for data, 7 to 0 for status). The CRC is then loaded with the new address low byte and folded with the next data byte. That CRC is returned before the next programming pulse.
- R7: Address bits above the field are forced to zero: the upper 9 bits for data commands and the upper 13 bits for status commands. The CRC is computed over the forced values.
- R8: Bit n of status byte 0 protects data page n (addresses 32n to 32n+31) when it is 0. A programming pulse then leaves the byte unchanged, and the verify returns that unchanged value.
- R9: Bits go out LSB first. A bus reset returns the block to S_IDLE from any state, with no trailing CRC.
- R10: A programming pulse in any state other than S_WAIT_PROG changes no stored byte.
- R11: An unknown command byte leads to S_BAD. There every read slot returns 1, further bytes and pulses have no effect, and only a bus reset leaves.
- R12: After rst_n, every data byte and status bytes 0 to 6 read FFh, and the idle output is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous-free synchronous reset of all state and storage |
| bus_reset | input | 1 | Single-cycle strobe: a bus reset was seen; aborts any command |
| rx_valid | input | 1 | Single-cycle strobe: rx_byte holds a received byte |
| rx_byte | input | 8 | Received byte, assembled LSB first by the bus interface |
| slot_rd | input | 1 | Single-cycle strobe: a read slot consumed tx_bit |
| prog_pulse | input | 1 | Single-cycle strobe: a programming pulse was detected |
| tx_bit | output | 1 | Bit to return in the next read slot |

## Verification
The hardest states to reach are the later passes of a write sequence. Reaching them needs a full command, a pulse timed into S_WAIT_PROG and a consumed verify byte before the seeded CRC appears. The field wrap and the protected pages only show up there. Directed sequences therefore start writes at byte 127 and at status byte 6 so that they cross the wrap. They also clear a protect bit before writing into the guarded page. A misplaced pulse is driven during S_SEND_CRC. Random multi-byte write sequences at random addresses follow, and full read-backs in all three read modes compare the array against the bench model.

// File: rtl/amem_pkg.sv
package amem_pkg;

    localparam logic [7:0] CMD_RD_MEM  = 8'hF0;
    localparam logic [7:0] CMD_RD_PAGE = 8'hC3;
    localparam logic [7:0] CMD_RD_STAT = 8'hAA;
    localparam logic [7:0] CMD_WR_MEM  = 8'h0F;
    localparam logic [7:0] CMD_WR_STAT = 8'h55;

    typedef enum logic [3:0] {
        S_IDLE,
        S_ADDR_LO,
        S_ADDR_HI,
        S_DATA,
        S_SEND_CRC,
        S_WAIT_PROG,
        S_PROG,
        S_VERIFY,
        S_RD_DATA,
        S_RD_CRC,
        S_ONES,
        S_BAD
    } ctl_state_t;

    typedef enum logic [2:0] {
        K_RD_MEM,
        K_RD_PAGE,
        K_RD_STAT,
        K_WR_MEM,
        K_WR_STAT,
        K_BAD
    } cmd_kind_t;

    typedef enum logic [1:0] {
        CRC_HOLD,
        CRC_FOLD,
        CRC_FRESH,
        CRC_SEED
    } crc_op_t;

    // CRC-8, polynomial x^8+x^5+x^4+1 in reflected form, bits taken LSB first
    function automatic logic [7:0] crc8_fold(input logic [7:0] acc, input logic [7:0] b);
        logic [7:0] c;
        logic       fb;
        c = acc;
        for (int i = 0; i < 8; i++) begin
            fb = c[0] ^ b[i];
            c  = {1'b0, c[7:1]};
            if (fb) c = c ^ 8'h8C;
        end
        return c;
    endfunction

endpackage

// File: rtl/amem_crc.sv
module amem_crc
    import amem_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  crc_op_t       op,
    input  logic [7:0]    din,
    output logic [7:0]    crc_q,
    output logic [7:0]    crc_nx
);

    always_comb begin
        unique case (op)
            CRC_HOLD:  crc_nx = crc_q;
            CRC_FOLD:  crc_nx = crc8_fold(crc_q, din);
            CRC_FRESH: crc_nx = crc8_fold(8'h00, din);
            CRC_SEED:  crc_nx = din;
            default:   crc_nx = crc_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) crc_q <= 8'h00;
        else        crc_q <= crc_nx;
    end

endmodule

// File: rtl/amem_tx.sv
module amem_tx #(
    parameter int BITS = 8,
    parameter int CW   = $clog2(BITS)
)(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clear,
    input  logic            load,
    input  logic [BITS-1:0] load_val,
    input  logic            slot,
    output logic            bit_out,
    output logic            byte_done
);

    logic [BITS-1:0] sr_q;
    logic [CW-1:0]   cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            sr_q  <= '1;
            cnt_q <= '0;
        end else if (load) begin
            sr_q  <= load_val;
            cnt_q <= '0;
        end else if (slot) begin
            sr_q  <= {1'b1, sr_q[BITS-1:1]};
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign bit_out   = sr_q[0];
    assign byte_done = slot && (cnt_q == CW'(BITS - 1));

endmodule

// File: rtl/amem_store.sv
module amem_store #(
    parameter int DATA_BYTES = 128,
    parameter int PAGE_BYTES = 32,
    parameter int STAT_BYTES = 8,
    parameter int AW         = $clog2(DATA_BYTES)
)(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          prog_en,
    input  logic          prog_stat,
    input  logic [AW-1:0] prog_addr,
    input  logic [7:0]    prog_val,
    input  logic          rd_stat,
    input  logic [AW-1:0] rd_addr,
    output logic [7:0]    rd_byte
);

    localparam int PW = $clog2(PAGE_BYTES);
    localparam int SW = $clog2(STAT_BYTES);
    localparam logic [SW-1:0] S_LAST = SW'(STAT_BYTES - 1);

    logic [DATA_BYTES-1:0][7:0]   data_q;
    logic [STAT_BYTES-2:0][7:0]   stat_q;
    logic [AW-PW-1:0]             pg;
    logic [SW-1:0]                ps_idx;
    logic [SW-1:0]                rs_idx;
    logic                         page_open;

    assign pg        = prog_addr[AW-1:PW];
    assign ps_idx    = prog_addr[SW-1:0];
    assign rs_idx    = rd_addr[SW-1:0];
    assign page_open = stat_q[0][pg];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '1;
            stat_q <= '1;
        end else if (prog_en) begin
            if (prog_stat) begin
                if (ps_idx != S_LAST) stat_q[ps_idx] <= stat_q[ps_idx] & prog_val;
            end else if (page_open) begin
                data_q[prog_addr] <= data_q[prog_addr] & prog_val;
            end
        end
    end

    always_comb begin
        if (rd_stat) rd_byte = (rs_idx == S_LAST) ? 8'h00 : stat_q[rs_idx];
        else         rd_byte = data_q[rd_addr];
    end

    // R5: programming only clears bits
    p_and_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((~$past(data_q) & data_q) == '0) && ((~$past(stat_q) & stat_q) == '0));

    // R8: a protected page is left untouched by a programming pulse
    p_wp_block_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_en && !prog_stat && !stat_q[0][pg]) |=> $stable(data_q));

endmodule

// File: rtl/amem_eprom_ctl.sv
module amem_eprom_ctl
    import amem_pkg::*;
#(
    parameter int PAGE_BYTES = 32,
    parameter int PAGES      = 4,
    parameter int STAT_BYTES = 8
)(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_reset,
    input  logic       rx_valid,
    input  logic [7:0] rx_byte,
    input  logic       slot_rd,
    input  logic       prog_pulse,
    output logic       tx_bit
);

    localparam int DATA_BYTES = PAGE_BYTES * PAGES;
    localparam int AW = $clog2(DATA_BYTES);
    localparam int PW = $clog2(PAGE_BYTES);
    localparam int SW = $clog2(STAT_BYTES);
    localparam logic [7:0] DMASK = 8'(DATA_BYTES - 1);
    localparam logic [7:0] SMASK = 8'(STAT_BYTES - 1);

    ctl_state_t    state_q, state_d;
    cmd_kind_t     kind_q, kind_d;
    logic          kind_ld;
    logic [AW-1:0] addr_q, addr_inc_val;
    logic          addr_ld, addr_inc;
    logic [7:0]    scratch_q;
    logic          scratch_ld;
    crc_op_t       crc_op;
    logic [7:0]    crc_din, crc_q, crc_nx;
    logic          tx_load;
    logic [7:0]    tx_val;
    logic          byte_done;
    logic          prog_en;
    logic [AW-1:0] rd_addr;
    logic [7:0]    rd_byte;
    logic          is_stat, is_write, last_in_field, page_end;
    logic [7:0]    lo_masked;

    assign is_stat   = (kind_q == K_RD_STAT) || (kind_q == K_WR_STAT);
    assign is_write  = (kind_q == K_WR_MEM)  || (kind_q == K_WR_STAT);
    assign lo_masked = rx_byte & (is_stat ? SMASK : DMASK);
    assign page_end  = &addr_q[PW-1:0];
    assign last_in_field = is_stat ? (addr_q[SW-1:0] == SW'(STAT_BYTES - 1))
                                   : (addr_q == AW'(DATA_BYTES - 1));

    always_comb begin
        addr_inc_val = addr_q + 1'b1;
        if (is_stat) begin
            addr_inc_val = '0;
            addr_inc_val[SW-1:0] = addr_q[SW-1:0] + 1'b1;
        end
    end

    amem_crc u_crc (
        .clk    (clk),
        .rst_n  (rst_n),
        .op     (crc_op),
        .din    (crc_din),
        .crc_q  (crc_q),
        .crc_nx (crc_nx)
    );

    amem_tx #(.BITS(8)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (bus_reset),
        .load      (tx_load),
        .load_val  (tx_val),
        .slot      (slot_rd),
        .bit_out   (tx_bit),
        .byte_done (byte_done)
    );

    amem_store #(
        .DATA_BYTES (DATA_BYTES),
        .PAGE_BYTES (PAGE_BYTES),
        .STAT_BYTES (STAT_BYTES),
        .AW         (AW)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .prog_en   (prog_en),
        .prog_stat (is_stat),
        .prog_addr (addr_q),
        .prog_val  (scratch_q),
        .rd_stat   (is_stat),
        .rd_addr   (rd_addr),
        .rd_byte   (rd_byte)
    );

    // state register and datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= S_IDLE;
            kind_q    <= K_BAD;
            addr_q    <= '0;
            scratch_q <= 8'hFF;
        end else if (bus_reset) begin
            state_q   <= S_IDLE;
        end else begin
            state_q <= state_d;
            if (kind_ld)    kind_q    <= kind_d;
            if (addr_ld)    addr_q    <= lo_masked[AW-1:0];
            else if (addr_inc) addr_q <= addr_inc_val;
            if (scratch_ld) scratch_q <= rx_byte;
        end
    end

    // next state and control outputs
    always_comb begin
        state_d    = state_q;
        kind_d     = K_BAD;
        kind_ld    = 1'b0;
        addr_ld    = 1'b0;
        addr_inc   = 1'b0;
        scratch_ld = 1'b0;
        crc_op     = CRC_HOLD;
        crc_din    = 8'h00;
        tx_load    = 1'b0;
        tx_val     = 8'hFF;
        prog_en    = 1'b0;
        rd_addr    = addr_q;

        unique case (state_q)
            S_IDLE: begin
                if (rx_valid) begin
                    crc_op  = CRC_FRESH;
                    crc_din = rx_byte;
                    kind_ld = 1'b1;
                    unique case (rx_byte)
                        CMD_RD_MEM:  kind_d = K_RD_MEM;
                        CMD_RD_PAGE: kind_d = K_RD_PAGE;
                        CMD_RD_STAT: kind_d = K_RD_STAT;
                        CMD_WR_MEM:  kind_d = K_WR_MEM;
                        CMD_WR_STAT: kind_d = K_WR_STAT;
                        default:     kind_d = K_BAD;
                    endcase
                    state_d = (kind_d == K_BAD) ? S_BAD : S_ADDR_LO;
                end
            end
            S_ADDR_LO: begin
                if (rx_valid) begin
                    crc_op  = CRC_FOLD;
                    crc_din = lo_masked;
                    addr_ld = 1'b1;
                    state_d = S_ADDR_HI;
                end
            end
            S_ADDR_HI: begin
                if (rx_valid) begin
                    crc_op  = CRC_FOLD;
                    crc_din = 8'h00;
                    if (is_write) begin
                        state_d = S_DATA;
                    end else begin
                        tx_load = 1'b1;
                        tx_val  = crc_nx;
                        state_d = S_SEND_CRC;
                    end
                end
            end
            S_DATA: begin
                if (rx_valid) begin
                    scratch_ld = 1'b1;
                    crc_op     = CRC_FOLD;
                    crc_din    = rx_byte;
                    tx_load    = 1'b1;
                    tx_val     = crc_nx;
                    state_d    = S_SEND_CRC;
                end
            end
            S_SEND_CRC: begin
                if (byte_done) begin
                    if (is_write) begin
                        state_d = S_WAIT_PROG;
                    end else begin
                        crc_op  = CRC_FRESH;
                        crc_din = rd_byte;
                        tx_load = 1'b1;
                        tx_val  = rd_byte;
                        state_d = S_RD_DATA;
                    end
                end
            end
            S_WAIT_PROG: begin
                if (prog_pulse && !bus_reset) begin
                    prog_en = 1'b1;
                    state_d = S_PROG;
                end
            end
            S_PROG: begin
                tx_load = 1'b1;
                tx_val  = rd_byte;
                state_d = S_VERIFY;
            end
            S_VERIFY: begin
                if (byte_done) begin
                    addr_inc = 1'b1;
                    crc_op   = CRC_SEED;
                    crc_din  = 8'(addr_inc_val);
                    state_d  = S_DATA;
                end
            end
            S_RD_DATA: begin
                if (byte_done) begin
                    if (last_in_field || (kind_q == K_RD_PAGE && page_end)) begin
                        tx_load = 1'b1;
                        tx_val  = crc_q;
                        state_d = S_RD_CRC;
                    end else begin
                        addr_inc = 1'b1;
                        rd_addr  = addr_inc_val;
                        crc_op   = CRC_FOLD;
                        crc_din  = rd_byte;
                        tx_load  = 1'b1;
                        tx_val   = rd_byte;
                    end
                end
            end
            S_RD_CRC: begin
                if (byte_done) begin
                    if (kind_q == K_RD_PAGE && !last_in_field) begin
                        addr_inc = 1'b1;
                        rd_addr  = addr_inc_val;
                        crc_op   = CRC_FRESH;
                        crc_din  = rd_byte;
                        tx_load  = 1'b1;
                        tx_val   = rd_byte;
                        state_d  = S_RD_DATA;
                    end else begin
                        state_d = S_ONES;
                    end
                end
            end
            S_ONES: state_d = S_ONES;
            S_BAD:  state_d = S_BAD;
            default: state_d = S_BAD;
        endcase
    end

    // R9: a bus reset always lands in the command wait
    p_bus_reset_r9: assert property (@(posedge clk) disable iff (!rst_n)
        bus_reset |=> (state_q == S_IDLE));

    // R2: past the final CRC the line stays high
    p_ones_tail_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_ONES) |-> tx_bit);

    // R11: an unknown command only returns ones
    p_bad_ones_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_BAD) |-> tx_bit);

    // R6: leaving the verify byte seeds the CRC with the new address
    p_seed_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_VERIFY && byte_done && !bus_reset)
        |=> (state_q == S_DATA && crc_q == 8'(addr_q)));

endmodule

// File: tb/amem_eprom_ctl_test.sv
module amem_eprom_ctl_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_reset = 1'b0;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_byte = 8'h00;
    logic       slot_rd = 1'b0;
    logic       prog_pulse = 1'b0;
    logic       tx_bit;

    int nchk = 0;
    int nerr = 0;
    logic [7:0] m_data [128];
    logic [7:0] m_stat [8];

    always #5 clk = ~clk;

    amem_eprom_ctl uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_reset  (bus_reset),
        .rx_valid   (rx_valid),
        .rx_byte    (rx_byte),
        .slot_rd    (slot_rd),
        .prog_pulse (prog_pulse),
        .tx_bit     (tx_bit)
    );

    function automatic logic [7:0] crc8(input logic [7:0] acc, input logic [7:0] b);
        logic [7:0] c = acc;
        for (int i = 0; i < 8; i++) begin
            if (c[0] ^ b[i]) c = (c >> 1) ^ 8'h8C;
            else             c = c >> 1;
        end
        return c;
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic put(input logic [7:0] b);
        @(negedge clk); rx_valid = 1'b1; rx_byte = b;
        @(negedge clk); rx_valid = 1'b0;
    endtask

    task automatic get(output logic [7:0] b);
        for (int i = 0; i < 8; i++) begin
            @(negedge clk); b[i] = tx_bit; slot_rd = 1'b1;
            @(negedge clk); slot_rd = 1'b0;
        end
    endtask

    task automatic pulse_prog;
        @(negedge clk); prog_pulse = 1'b1;
        @(negedge clk); prog_pulse = 1'b0;
    endtask

    task automatic pulse_reset;
        @(negedge clk); bus_reset = 1'b1;
        @(negedge clk); bus_reset = 1'b0;
    endtask

    task automatic rd_mem(input logic [15:0] start, input string tag);
        logic [7:0] got, c, lo;
        lo = start[7:0] & 8'h7F;
        put(8'hF0); put(start[7:0]); put(start[15:8]);
        get(got); chk({tag, " R1 cmd crc"}, got, crc8(crc8(crc8(8'h00, 8'hF0), lo), 8'h00));
        c = 8'h00;
        for (int a = int'(lo); a < 128; a++) begin
            get(got); chk({tag, " R2 data"}, got, m_data[a]);
            c = crc8(c, m_data[a]);
        end
        get(got); chk({tag, " R2 end crc"}, got, c);
        get(got); chk({tag, " R2 ones"}, got, 8'hFF);
        pulse_reset;
    endtask

    task automatic rd_page(input logic [15:0] start, input string tag);
        logic [7:0] got, c, lo;
        int a;
        lo = start[7:0] & 8'h7F;
        a = int'(lo);
        put(8'hC3); put(start[7:0]); put(start[15:8]);
        get(got); chk({tag, " R1 cmd crc"}, got, crc8(crc8(crc8(8'h00, 8'hC3), lo), 8'h00));
        for (int pg = 0; pg < 4; pg++) begin
            c = 8'h00;
            for (int k = 0; k < 32; k++) begin
                get(got); chk({tag, " R3 data"}, got, m_data[a]);
                c = crc8(c, m_data[a]);
                if (a % 32 == 31) break;
                a++;
            end
            get(got); chk({tag, " R3 page crc"}, got, c);
            if (a == 127) break;
            a++;
        end
        get(got); chk({tag, " R3 ones"}, got, 8'hFF);
        pulse_reset;
    endtask

    task automatic rd_stat(input logic [15:0] start, input string tag);
        logic [7:0] got, c, lo;
        lo = start[7:0] & 8'h07;
        put(8'hAA); put(start[7:0]); put(start[15:8]);
        get(got); chk({tag, " R7 cmd crc"}, got, crc8(crc8(crc8(8'h00, 8'hAA), lo), 8'h00));
        c = 8'h00;
        for (int a = int'(lo); a < 8; a++) begin
            get(got); chk({tag, " R4 status"}, got, m_stat[a]);
            c = crc8(c, m_stat[a]);
        end
        get(got); chk({tag, " R4 crc"}, got, c);
        get(got); chk({tag, " R4 ones"}, got, 8'hFF);
        pulse_reset;
    endtask

    task automatic wr_seq(input bit st, input logic [15:0] start, input int n,
                          input logic [7:0] d0, input string tag);
        logic [7:0] cmd, lo, c, d, got, expv;
        int a, mask;
        cmd  = st ? 8'h55 : 8'h0F;
        mask = st ? 7 : 127;
        lo   = start[7:0] & 8'(mask);
        a    = int'(lo);
        put(cmd); put(start[7:0]); put(start[15:8]);
        d = d0;
        put(d);
        c = crc8(crc8(crc8(crc8(8'h00, cmd), lo), 8'h00), d);
        for (int k = 0; k < n; k++) begin
            if (k > 0) begin
                d = 8'($urandom);
                put(d);
                c = crc8(8'(a), d);
            end
            get(got);
            chk({tag, (k == 0) ? " R1 write crc" : " R6 seeded crc"}, got, c);
            pulse_prog;
            if (st) begin
                if (a != 7) m_stat[a] = m_stat[a] & d;
            end else if (m_stat[0][a / 32]) begin
                m_data[a] = m_data[a] & d;
            end
            expv = st ? m_stat[a] : m_data[a];
            get(got); chk({tag, " verify"}, got, expv);
            a = (a + 1) & mask;
        end
        pulse_reset;
    endtask

    task automatic finish_up;
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nchk++;
        nerr++;
        $display("FAIL watchdog: actual hung expected complete");
        finish_up;
    end

    initial begin
        logic [7:0] got;
        int unsigned seed_v;
        seed_v = $urandom(32'h1F2E3D4C);
        for (int i = 0; i < 128; i++) m_data[i] = 8'hFF;
        for (int i = 0; i < 7; i++)   m_stat[i] = 8'hFF;
        m_stat[7] = 8'h00;

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R12 idle line", {7'h0, tx_bit}, 8'h01);
        rd_mem(16'h0000, "R12");
        rd_stat(16'h0000, "R12");

        wr_seq(1'b0, 16'h0010, 3, 8'hA5, "R5");
        wr_seq(1'b0, 16'h0010, 1, 8'h0F, "R5 and");
        wr_seq(1'b0, 16'h007F, 2, 8'h3C, "R6 wrap");
        wr_seq(1'b1, 16'h0006, 3, 8'h81, "R4 last byte");
        wr_seq(1'b1, 16'h0000, 1, 8'hFD, "R8 set protect");
        wr_seq(1'b0, 16'h0025, 2, 8'h00, "R8 blocked");
        wr_seq(1'b0, 16'hFF45, 1, 8'h77, "R7 high addr");
        rd_stat(16'hFFF3, "R7");
        rd_mem(16'h0185, "R7");
        rd_page(16'h0033, "R3");

        // R10: pulse while the command CRC is pending and while idle
        put(8'h0F); put(8'h40); put(8'h00); put(8'h00);
        pulse_prog;
        get(got); chk("R10 crc", got, crc8(crc8(crc8(crc8(8'h00, 8'h0F), 8'h40), 8'h00), 8'h00));
        pulse_reset;
        pulse_prog;
        rd_mem(16'h0040, "R10");

        // R11: unknown command
        put(8'h12);
        get(got); chk("R11 ones", got, 8'hFF);
        put(8'hF0); put(8'h00); put(8'h00);
        get(got); chk("R11 still ones", got, 8'hFF);
        pulse_prog;
        pulse_reset;
        rd_mem(16'h0000, "R11");

        // R9: early abort during data and during address
        put(8'hF0); put(8'h10); put(8'h00);
        get(got); chk("R9 crc", got, crc8(crc8(crc8(8'h00, 8'hF0), 8'h10), 8'h00));
        get(got); chk("R9 first", got, m_data[16]);
        get(got); chk("R9 second", got, m_data[17]);
        pulse_reset;
        put(8'hAA); put(8'h01);
        pulse_reset;
        rd_stat(16'h0002, "R9");

        for (int r = 0; r < 10; r++) begin
            wr_seq(1'($urandom % 2), 16'($urandom), 1 + int'($urandom % 4), 8'($urandom), "R5 random");
        end
        rd_mem(16'h0000, "R2 final");
        rd_page(16'h0000, "R3 final");
        rd_stat(16'h0000, "R4 final");
        finish_up;
    end

endmodule